// File: doc/BRIEF.md
# Neuron Forward Activation Unit

This block evaluates one neuron of a network whose layers are all simulated on a single physical layer of neurons. A layer index selects which slice of the neuron's local weight memory is used. For each pass, the block works through the previous layer's activations one at a time. Each activation and its weight go to a multiplier that the block does not own, and the products are summed into the synaptic potential. That potential then goes through a logistic transfer function, built from a sampled table with linear interpolation between neighbouring samples. The block registers the neuron output, the difference between a supplied target and that output, and a completion flag.

All values are signed fixed point with 16 integer and 16 fraction bits. A controller reuses the block once per simulated layer. It presents the previous layer's activations, the layer index (up to 127) and the number of previous-layer neurons, then pulses a start strobe and waits for the completion flag. The weight memory is read through a combinational address/data port. The multiplier is reached through an operand port that returns the full 64-bit product one clock later.

Top module: `neuron_fwd_unit`

## Requirements
- R1: While reset is held, and after it is released, `ready`, `outY`, `outErr` and `mulGo` are all zero until a computation finishes.
- R2: A `start` pulse sampled while the unit is idle begins a computation. A `start` pulse sampled while a computation is in progress has no effect on the result, on the number of multiplier requests or on the latency.
- R3: While accumulating, the unit raises `mulGo` for exactly `prevCount` consecutive cycles, one per input k = 0, 1, 2, ... in rising order. In the cycle for input k, `wgtAddr` = layerIdx * MAX_IN + k, `mulA` equals `wgtData` and `mulB` equals activation k. Activation k sits in bits [32k+31:32k] of `actVec`.
- R4: The potential is the 32-bit wrapping sum of every product returned on `mulP`, each product reduced to 16.16 by keeping bits 47:16 of the 64-bit value.
- R5: For a potential x with -8.0 <= x < 8.0, the output is L[s] + floor((L[s+1] - L[s]) * f / 16384), where u = x + 8.0 in 16.16 units, s = u >> 14, f = u mod 16384, and L[i] = round(65536 / (1 + exp(-(-8 + 0.25 i)))) for i = 0..64.
- R6: A potential below -8.0 gives an output of exactly 0. A potential of 8.0 or more gives an output of exactly 65536 (1.0).
- R7: `outErr` equals `target` minus `outY`, taken modulo 2^32.
- R8: `ready` rises exactly prevCount + 3 clock edges after the edge that samples an accepted `start`. It then holds, with `outY` and `outErr` unchanged, until the next accepted `start`, which clears it at the sampling edge.
- R9: With `prevCount` = 0, no multiplier request is made and the output is the table value at zero, 32768 (0.5).
- R10: The layer index is captured at the accepted `start`. Layer 127 addresses weights 1016 to 1023 when MAX_IN is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a neuron evaluation (taken only when idle) |
| layerIdx | input | LAYER_W (7) | Layer currently simulated; selects the weight slice |
| prevCount | input | IDX_W (4) | Number of previous-layer neurons, 0..MAX_IN |
| actVec | input | MAX_IN*DATA_W (256) | Previous-layer activations, 16.16 each |
| target | input | DATA_W (32) | Target value for the error output |
| wgtAddr | output | ADDR_W (10) | Weight memory read address |
| wgtData | input | DATA_W (32) | Weight read from the addressed word, same cycle |
| mulA | output | DATA_W (32) | Multiplier operand: weight |
| mulB | output | DATA_W (32) | Multiplier operand: activation |
| mulGo | output | 1 | Operands on mulA/mulB are valid this cycle |
| mulP | input | 2*DATA_W (64) | Signed product of the operands sent one cycle earlier |
| outY | output | DATA_W (32) | Neuron output, 0..65536 |
| outErr | output | DATA_W (32) | target minus output |
| ready | output | 1 | Result valid; held until next accepted start |

## Verification
The properties assume that `prevCount` never exceeds MAX_IN. They also assume that `actVec` and `target` stay constant from the accepted `start` until `ready` rises, and that `mulP` carries the product of the operands issued one cycle earlier. The bench keeps to these rules: it changes the operands only at falling edges while the unit is idle, and it models the multiplier as a one-cycle registered signed product. The one deliberate exception is a second `start` sent in the middle of a pass with a different layer and count. The activations and target stay untouched during that pass, so the only thing being tested is whether the late strobe is ignored.

// File: rtl/nfu_pkg.sv
package nfu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_XFER = 2'd2,
    ST_OUT  = 2'd3
  } nfuState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrSum;    // start accepted: clear potential and ready
    logic issue;     // send one operand pair to the multiplier
    logic capSig;    // capture transfer-function result
    logic latchOut;  // register output, error and ready
  } nfuCtrl_t;

endpackage

// File: rtl/nfu_sigmoid.sv
module nfu_sigmoid #(
  parameter int DATA_W     = 32,
  parameter int FRAC_W     = 16,
  parameter int RANGE_LOG2 = 3,
  parameter int SEG_LOG2   = 6
) (
  input  logic signed [DATA_W-1:0] x,
  output logic        [DATA_W-1:0] y
);

  localparam int SEGS      = 1 << SEG_LOG2;
  localparam int U_W       = FRAC_W + RANGE_LOG2 + 1;
  localparam int SEG_SHIFT = U_W - SEG_LOG2;
  localparam logic signed [DATA_W-1:0] LIM = DATA_W'(64'd1 << (FRAC_W + RANGE_LOG2));
  localparam logic [DATA_W-1:0] ONE = DATA_W'(64'd1 << FRAC_W);

  function automatic logic [DATA_W-1:0] sampleAt(input int i);
    real xr;
    xr = -(2.0 ** RANGE_LOG2) + real'(i) * (2.0 ** (RANGE_LOG2 + 1)) / real'(SEGS);
    return DATA_W'($rtoi((2.0 ** FRAC_W) / (1.0 + $exp(-xr)) + 0.5));
  endfunction

  logic [DATA_W-1:0] tab [SEGS+1];

  for (genvar gi = 0; gi <= SEGS; gi++) begin : g_tab
    localparam logic [DATA_W-1:0] SAMPLE = sampleAt(gi);
    assign tab[gi] = SAMPLE;
  end

  logic [DATA_W-1:0]     uFull;
  logic [SEG_LOG2:0]     segX;
  logic [SEG_SHIFT-1:0]  fr;
  logic [DATA_W-1:0]     loV, hiV, delta;
  logic [2*DATA_W-1:0]   slope;

  always_comb begin
    uFull = DATA_W'(x + LIM);
    segX  = (SEG_LOG2+1)'(uFull >> SEG_SHIFT);
    fr    = SEG_SHIFT'(uFull);
    loV   = tab[segX];
    hiV   = tab[segX + (SEG_LOG2+1)'(1)];
    delta = hiV - loV;
    slope = {{DATA_W{1'b0}}, delta} * {{(2*DATA_W-SEG_SHIFT){1'b0}}, fr};
    if (x < -LIM)
      y = '0;
    else if (x >= LIM)
      y = ONE;
    else
      y = loV + DATA_W'(slope >> SEG_SHIFT);
  end

endmodule

// File: rtl/nfu_ctrl.sv
module nfu_ctrl
  import nfu_pkg::*;
#(
  parameter int MAX_IN  = 8,
  parameter int LAYER_W = 7,
  parameter int IDX_W   = $clog2(MAX_IN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [LAYER_W-1:0] layerIdx,
  input  logic [IDX_W-1:0]   prevCount,
  output logic [IDX_W-1:0]   idx,
  output logic [LAYER_W-1:0] layerLat,
  output nfuCtrl_t           ctl
);

  nfuState_e         state;
  logic [IDX_W-1:0]  cntLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      cntLat   <= '0;
      layerLat <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_ACC;
          idx      <= '0;
          cntLat   <= prevCount;
          layerLat <= layerIdx;
        end
        ST_ACC: begin
          if (idx == cntLat) state <= ST_XFER;
          else               idx   <= idx + IDX_W'(1);
        end
        ST_XFER: state <= ST_OUT;
        ST_OUT:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: ctl.clrSum   = start;
      ST_ACC:  ctl.issue    = (idx != cntLat);
      ST_XFER: ctl.capSig   = 1'b1;
      ST_OUT:  ctl.latchOut = 1'b1;
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/nfu_dpath.sv
module nfu_dpath
  import nfu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FRAC_W     = 16,
  parameter int MAX_IN     = 8,
  parameter int LAYER_W    = 7,
  parameter int RANGE_LOG2 = 3,
  parameter int SEG_LOG2   = 6,
  parameter int IDX_W      = $clog2(MAX_IN + 1),
  parameter int ADDR_W     = LAYER_W + $clog2(MAX_IN)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  nfuCtrl_t                 ctl,
  input  logic [IDX_W-1:0]         idx,
  input  logic [LAYER_W-1:0]       layerLat,
  input  logic [MAX_IN*DATA_W-1:0] actVec,
  input  logic [DATA_W-1:0]        target,
  input  logic [DATA_W-1:0]        wgtData,
  input  logic [2*DATA_W-1:0]      mulP,
  output logic [ADDR_W-1:0]        wgtAddr,
  output logic [DATA_W-1:0]        mulA,
  output logic [DATA_W-1:0]        mulB,
  output logic                     mulGo,
  output logic [DATA_W-1:0]        outY,
  output logic [DATA_W-1:0]        outErr,
  output logic                     ready
);

  logic [DATA_W-1:0] act [MAX_IN];

  for (genvar g = 0; g < MAX_IN; g++) begin : g_act
    assign act[g] = actVec[g*DATA_W +: DATA_W];
  end

  // Operand selection and weight slice addressing
  always_comb begin
    mulB = '0;
    for (int k = 0; k < MAX_IN; k++)
      if (idx == IDX_W'(k)) mulB = act[k];
  end

  assign wgtAddr = ADDR_W'(layerLat) * ADDR_W'(MAX_IN) + ADDR_W'(idx);
  assign mulA    = wgtData;
  assign mulGo   = ctl.issue;

  // Product returns one cycle after issue
  logic              pVld;
  logic [DATA_W-1:0] sumQ;
  logic [DATA_W-1:0] sigY;
  logic [DATA_W-1:0] sigQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pVld <= 1'b0;
      sumQ <= '0;
    end else begin
      pVld <= ctl.issue;
      if (ctl.clrSum)
        sumQ <= '0;
      else if (pVld)
        sumQ <= sumQ + DATA_W'(mulP >> FRAC_W);
    end
  end

  nfu_sigmoid #(
    .DATA_W    (DATA_W),
    .FRAC_W    (FRAC_W),
    .RANGE_LOG2(RANGE_LOG2),
    .SEG_LOG2  (SEG_LOG2)
  ) uSig (
    .x(signed'(sumQ)),
    .y(sigY)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigQ   <= '0;
      outY   <= '0;
      outErr <= '0;
      ready  <= 1'b0;
    end else begin
      if (ctl.capSig) sigQ <= sigY;
      if (ctl.clrSum) begin
        ready <= 1'b0;
      end else if (ctl.latchOut) begin
        outY   <= sigQ;
        outErr <= target - sigQ;
        ready  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/neuron_fwd_unit.sv
module neuron_fwd_unit
  import nfu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FRAC_W     = 16,
  parameter int MAX_IN     = 8,
  parameter int LAYER_W    = 7,
  parameter int RANGE_LOG2 = 3,
  parameter int SEG_LOG2   = 6,
  parameter int IDX_W      = $clog2(MAX_IN + 1),
  parameter int ADDR_W     = LAYER_W + $clog2(MAX_IN)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [LAYER_W-1:0]       layerIdx,
  input  logic [IDX_W-1:0]         prevCount,
  input  logic [MAX_IN*DATA_W-1:0] actVec,
  input  logic [DATA_W-1:0]        target,
  output logic [ADDR_W-1:0]        wgtAddr,
  input  logic [DATA_W-1:0]        wgtData,
  output logic [DATA_W-1:0]        mulA,
  output logic [DATA_W-1:0]        mulB,
  output logic                     mulGo,
  input  logic [2*DATA_W-1:0]      mulP,
  output logic [DATA_W-1:0]        outY,
  output logic [DATA_W-1:0]        outErr,
  output logic                     ready
);

  nfuCtrl_t           ctl;
  logic [IDX_W-1:0]   idx;
  logic [LAYER_W-1:0] layerLat;

  nfu_ctrl #(
    .MAX_IN (MAX_IN),
    .LAYER_W(LAYER_W),
    .IDX_W  (IDX_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .layerIdx (layerIdx),
    .prevCount(prevCount),
    .idx      (idx),
    .layerLat (layerLat),
    .ctl      (ctl)
  );

  nfu_dpath #(
    .DATA_W    (DATA_W),
    .FRAC_W    (FRAC_W),
    .MAX_IN    (MAX_IN),
    .LAYER_W   (LAYER_W),
    .RANGE_LOG2(RANGE_LOG2),
    .SEG_LOG2  (SEG_LOG2),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .idx     (idx),
    .layerLat(layerLat),
    .actVec  (actVec),
    .target  (target),
    .wgtData (wgtData),
    .mulP    (mulP),
    .wgtAddr (wgtAddr),
    .mulA    (mulA),
    .mulB    (mulB),
    .mulGo   (mulGo),
    .outY    (outY),
    .outErr  (outErr),
    .ready   (ready)
  );

endmodule

// File: rtl/nfu_checks.sv
module nfu_checks #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              ready,
  input logic              mulGo,
  input logic [IDX_W-1:0]  prevCount,
  input logic [ADDR_W-1:0] wgtAddr,
  input logic [DATA_W-1:0] outY,
  input logic [DATA_W-1:0] outErr,
  input logic [DATA_W-1:0] target
);

  localparam int LAT_W = IDX_W + 3;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(64'd1 << FRAC_W);

  logic             busyC;
  logic [IDX_W-1:0] expN;
  logic [IDX_W-1:0] goCnt;
  logic [LAT_W-1:0] lat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyC <= 1'b0;
      expN  <= '0;
      goCnt <= '0;
      lat   <= '0;
    end else if (start && !busyC) begin
      busyC <= 1'b1;
      expN  <= prevCount;
      goCnt <= '0;
      lat   <= '0;
    end else if (busyC) begin
      if (mulGo) goCnt <= goCnt + IDX_W'(1);
      lat <= lat + LAT_W'(1);
      if (ready) busyC <= 1'b0;
    end
  end

  // R3: one request per input, no more, no fewer
  a_r3_go_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> goCnt == expN);

  // R3: weight addresses step by one across the requests
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    mulGo && $past(mulGo) |-> wgtAddr == $past(wgtAddr) + ADDR_W'(1));

  // R2: no requests while a finished result is presented
  a_r2_go_busy: assert property (@(posedge clk) disable iff (!rstN)
    mulGo |-> !ready);

  // R8: fixed latency from accepted start
  a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> lat == LAT_W'(expN) + LAT_W'(3));

  // R8: accepted start clears ready
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    ready && start |=> !ready);

  // R8: results hold while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    ready && !start |=> ready && $stable(outY) && $stable(outErr));

  // R6: output never leaves the unit interval
  a_r6_range: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> outY <= ONE);

  // R7: error relation at completion
  a_r7_error: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> outErr == target - outY);

endmodule

bind neuron_fwd_unit nfu_checks #(
  .DATA_W(DATA_W),
  .FRAC_W(FRAC_W),
  .IDX_W (IDX_W),
  .ADDR_W(ADDR_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .ready    (ready),
  .mulGo    (mulGo),
  .prevCount(prevCount),
  .wgtAddr  (wgtAddr),
  .outY     (outY),
  .outErr   (outErr),
  .target   (target)
);

// File: tb/sim_neuron_fwd_unit.sv
`timescale 1ns/1ps
module sim_neuron_fwd_unit;

  localparam int DATA_W = 32;
  localparam int MAX_IN = 8;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = 10;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     start = 1'b0;
  logic [6:0]               layerIdx = '0;
  logic [IDX_W-1:0]         prevCount = '0;
  logic [MAX_IN*DATA_W-1:0] actVec = '0;
  logic [DATA_W-1:0]        target = '0;
  logic [ADDR_W-1:0]        wgtAddr;
  logic [DATA_W-1:0]        wgtData;
  logic [DATA_W-1:0]        mulA, mulB;
  logic                     mulGo;
  logic [2*DATA_W-1:0]      mulP = '0;
  logic [DATA_W-1:0]        outY, outErr;
  logic                     ready;

  always #10 clk = ~clk;

  int wmem [1024];
  assign wgtData = wmem[wgtAddr];

  always @(posedge clk) mulP <= $signed(mulA) * $signed(mulB);

  neuron_fwd_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .layerIdx(layerIdx),
    .prevCount(prevCount), .actVec(actVec), .target(target),
    .wgtAddr(wgtAddr), .wgtData(wgtData), .mulA(mulA), .mulB(mulB),
    .mulGo(mulGo), .mulP(mulP), .outY(outY), .outErr(outErr), .ready(ready)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tabRef(input int i);
    real xr;
    xr = -8.0 + 0.25 * real'(i);
    return $rtoi(65536.0 / (1.0 + $exp(-xr)) + 0.5);
  endfunction

  function automatic int sigRef(input int x);
    int u, s, f, l0, l1;
    if (x < -524288) return 0;
    if (x >= 524288) return 65536;
    u = x + 524288;
    s = u >>> 14;
    f = u & 16383;
    l0 = tabRef(s);
    l1 = tabRef(s + 1);
    return l0 + ((l1 - l0) * f) / 16384;
  endfunction

  typedef struct {
    int     y;
    int     err;
    int     n;
    longint startCyc;
    string  req;
  } item_t;

  item_t  q[$];
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // expected operand stream for the run in flight
  int goBase;
  int goActs [MAX_IN];
  int goIdx;
  bit readyQ = 0;

  // Monitor: operand stream and result scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (mulGo) begin
        check(wgtAddr == ADDR_W'(goBase + goIdx), "R3", "weight address", wgtAddr, goBase + goIdx);
        check(mulA == wmem[wgtAddr], "R3", "weight operand", mulA, wmem[wgtAddr]);
        check(goIdx < MAX_IN && mulB == goActs[goIdx], "R3", "activation operand", mulB,
              goIdx < MAX_IN ? goActs[goIdx] : 0);
        goIdx++;
      end
      if (ready && !readyQ) begin
        if (q.size() == 0) begin
          check(0, "R2", "unexpected result", outY, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(outY == it.y, it.req, "output", $signed(outY), it.y);
          check(outErr == it.err, "R7", "error", $signed(outErr), it.err);
          check(cyc - it.startCyc == it.n + 3, "R8", "latency", cyc - it.startCyc, it.n + 3);
          check(goIdx == it.n, "R3", "request count", goIdx, it.n);
        end
      end
      readyQ = ready;
    end
  end

  // Driver: computes expectation, pushes it, pulses start
  task automatic runOne(input int layer, input int n, input int acts[MAX_IN],
                        input int tgt, input string req, input bit poke);
    int s;
    longint p;
    item_t it;
    logic [DATA_W-1:0] hy;
    int waited;
    @(negedge clk);
    s = 0;
    for (int k = 0; k < n; k++) begin
      p = longint'(wmem[layer*MAX_IN + k]) * longint'(acts[k]);
      s = s + int'(p >>> 16);
    end
    it.y = sigRef(s);
    it.err = tgt - it.y;
    it.n = n;
    it.startCyc = cyc + 1;
    it.req = req;
    q.push_back(it);
    goBase = layer * MAX_IN;
    goIdx = 0;
    for (int k = 0; k < MAX_IN; k++) begin
      goActs[k] = acts[k];
      actVec[k*DATA_W +: DATA_W] = acts[k];
    end
    layerIdx = 7'(layer);
    prevCount = IDX_W'(n);
    target = tgt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b0, "R8", "ready cleared by start", ready, 0);
    if (poke) begin
      @(negedge clk);
      layerIdx = 7'd5;
      prevCount = IDX_W'(2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (q.size() != 0 && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    check(q.size() == 0, "R8", "result arrived", waited, n + 3);
    @(negedge clk);
    hy = outY;
    repeat (3) @(negedge clk);
    check(ready == 1'b1 && outY == hy, "R8", "result held", outY, hy);
  endtask

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFail);
      $finish;
    end
  end

  initial begin
    int acts [MAX_IN];
    for (int a = 0; a < 1024; a++) wmem[a] = (((a * 37 + 11) % 97) - 48) * 2731 + 1000;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(ready == 0 && mulGo == 0, "R1", "ready/mulGo in reset", {ready, mulGo}, 0);
    check(outY == 0 && outErr == 0, "R1", "outputs in reset", outY | outErr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(ready == 0 && mulGo == 0 && outY == 0, "R1", "state after release", {ready, mulGo}, 0);

    // R4/R5: small mixed-sign pattern
    acts = '{65536, -32768, 16384, 0, 0, 0, 0, 0};
    runOne(2, 3, acts, 40000, "R4", 0);

    // R10: top layer, full fan-in
    acts = '{30000, -20000, 65536, -65536, 12345, -5000, 8000, 100};
    runOne(127, 8, acts, 0, "R10", 0);

    // R9: no inputs
    runOne(9, 0, acts, 65536, "R9", 0);

    // R6/R5: boundaries of the table span
    acts = '{65536, 0, 0, 0, 0, 0, 0, 0};
    wmem[3*MAX_IN] = 524288;
    runOne(3, 1, acts, 0, "R6", 0);
    wmem[3*MAX_IN] = 524287;
    runOne(3, 1, acts, 0, "R5", 0);
    wmem[3*MAX_IN] = -524288;
    runOne(3, 1, acts, 0, "R5", 0);
    wmem[3*MAX_IN] = -524289;
    runOne(3, 1, acts, 0, "R6", 0);
    acts = '{6553600, 6553600, 0, 0, 0, 0, 0, 0};
    wmem[4*MAX_IN] = 131072; wmem[4*MAX_IN+1] = 131072;
    runOne(4, 2, acts, 0, "R6", 0);

    // R7: error wraps
    acts = '{65536, 0, 0, 0, 0, 0, 0, 0};
    runOne(6, 1, acts, 32'sh8000_0005, "R7", 0);

    // R2: a start during a pass is ignored
    acts = '{50000, -40000, 30000, -20000, 10000, 5000, -2500, 1250};
    runOne(11, 8, acts, 1000, "R2", 1);

    // R4/R5: assorted patterns
    for (int t = 0; t < 12; t++) begin
      int n, layer, tgt;
      for (int k = 0; k < MAX_IN; k++) acts[k] = int'(nextRand() % 131072) - 65536;
      n = int'(nextRand() % 9);
      layer = int'(nextRand() % 128);
      tgt = int'(nextRand() % 65537);
      runOne(layer, n, acts, tgt, "R5", 0);
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule